// File: doc/BRIEF.md
# Auto-Reload Interval Timer

This block is an up-counting interval timer that sits behind a simple single-cycle register bus. A clock divider slows the count: the counter moves one step for every DIV+1 clock cycles, and only while the run bit is set. When the count steps onto the programmed reload value, the block raises bit 0 of its flag register and drives a one-cycle interrupt pulse, provided the interrupt enable is on. On the following tick the count returns to zero. Software can load the count directly, force it to zero through an event-generation register, and retune the divider without disturbing the current count.

The bus decodes a 1 KiB window of 32-bit word registers. Several registers (compare values, compare mode, output enable, slave configuration, DMA configuration and address, option) are plain storage with no side effects. Reads are combinational and writes take effect at the clock edge that ends the request cycle. An asynchronous active-low reset clears every register and the count, and its release is synchronised inside the block.

Top module: `reload_timer`

## Requirements
- R1: After reset every mapped register reads 0, the count reads 0 and the interrupt output is low.
- R2: With the run bit (bit 0 at offset 0x000) set, the count at offset 0x024 advances by one every DIV+1 clock cycles; with the run bit clear the count holds its value.
- R3: On the tick that follows the count reaching a nonzero reload value (offset 0x02C), the count returns to 0.
- R4: When the count steps onto a nonzero reload value, flag bit 0 (offset 0x010) is set and the interrupt output is high for exactly one cycle, but only if interrupt-enable bit 0 (offset 0x00C) and the run bit are both 1.
- R5: A write to the flag register stores the old flags ANDed with the written data: writing 0 to a bit clears it, writing 1 leaves it unchanged.
- R6: With a reload value of 0 no event is raised: no flag, no interrupt, and the count runs on past any value.
- R7: A write to offset 0x014 with bit 0 set forces the count to 0 and restarts the divider phase; the written word reads back unchanged.
- R8: A write to offset 0x024 replaces the count with the written value and restarts the divider phase.
- R9: A write to the divider (offset 0x028) keeps only the low 16 bits, keeps the current count, and restarts the divider phase so that the new rate applies from that edge.
- R10: Offsets 0x030 and 0x044 and any other unmapped word read 0 and ignore writes; the compare registers (0x034 to 0x040), the DMA configuration and address words (0x048, 0x04C) and the option word (0x050) read back what was written.
- R11: Read data is presented in the same cycle as the read request and is 0 in cycles with no read request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access request in this cycle |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 10 | Byte address inside the 1 KiB window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| irq_o | output | 1 | One-cycle update interrupt pulse |

## Verification
Read data is due in the request cycle itself, while a write shows up in any read issued in the cycle after the write edge; the interrupt pulse is registered, so it is visible in the cycle that follows the edge on which the count steps onto the reload value. The bench issues one bus operation per cycle from the falling edge, samples both read data and the interrupt one time unit later, and every expected count in the vector table was worked out by counting edges from the write that enabled or reloaded the counter. The directed tests count idle cycles the same way, so that a divider change is checked just before and just after the first slowed tick.

// File: rtl/rtim_pkg.sv
package rtim_pkg;

  // Word indices (byte offset / 4) with side effects.
  localparam int W_FLAGS = 4;
  localparam int W_EVGEN = 5;
  localparam int W_COUNT = 9;
  localparam int W_DIV   = 10;

  // Plain storage words; slot numbers below select their role.
  localparam int NUM_PLAIN = 16;
  localparam int PLAIN_IDX [NUM_PLAIN] = '{
    0, 3, 5, 11,          // control, irq enable, event gen, reload
    1, 2, 6, 7, 8,        // control 2, slave cfg, cmp mode 0/1, cmp enable
    13, 14, 15, 16,       // compare 0..3
    18, 19, 20            // dma cfg, dma addr, option
  };
  localparam int SLOT_CTRL   = 0;
  localparam int SLOT_IRQEN  = 1;
  localparam int SLOT_EVGEN  = 2;
  localparam int SLOT_RELOAD = 3;

endpackage

// File: rtl/rtim_prescaler.sv
module rtim_prescaler #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             restart_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);

  logic [DIV_W-1:0] phase_q, phase_d;

  assign tick_o = run_i && (phase_q == div_i);

  always_comb begin
    phase_d = phase_q;
    if (restart_i)   phase_d = '0;
    else if (tick_o) phase_d = '0;
    else if (run_i)  phase_d = phase_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_d;
  end

  // R9: the phase never passes the divider, even across divider writes
  p_phase_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q <= div_i);

endmodule

// File: rtl/rtim_counter.sv
module rtim_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic [CNT_W-1:0] reload_i,
  input  logic             uie_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             evt_o,
  output logic             irq_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             irq_q;
  logic             reload_live;
  logic             hit;

  assign reload_live = (reload_i != '0);

  always_comb begin
    hit   = tick_i && !load_i && reload_live && ((cnt_q + CNT_W'(1)) == reload_i);
    evt_o = hit && uie_i;
    cnt_d = cnt_q;
    if (load_i)
      cnt_d = load_val_i;
    else if (tick_i)
      cnt_d = (reload_live && (cnt_q == reload_i)) ? '0 : cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      irq_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      irq_q <= evt_o;
    end
  end

  assign cnt_o = cnt_q;
  assign irq_o = irq_q;

  p_hold_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !load_i) |=> $stable(cnt_q));

  p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !load_i && (reload_i != '0) && (cnt_q == reload_i)) |=> (cnt_q == '0));

  p_irq_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o);

  p_no_event_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (reload_i == '0) |=> !irq_o);

  p_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (cnt_q == $past(load_val_i)));

endmodule

// File: rtl/rtim_regs.sv
module rtim_regs
  import rtim_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 10,
  parameter int DIV_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [DATA_W-1:0] cnt_i,
  input  logic              flag_set_i,
  output logic              run_o,
  output logic              uie_o,
  output logic [DIV_W-1:0]  div_o,
  output logic [DATA_W-1:0] reload_o,
  output logic              cnt_load_o,
  output logic [DATA_W-1:0] cnt_load_val_o,
  output logic              div_restart_o
);

  localparam int WIDX_W = ADDR_W - 2;

  logic [WIDX_W-1:0] widx;
  logic              wr_en, rd_en;
  logic              wr_flags, wr_count, wr_div, wr_evgen;
  logic [NUM_PLAIN-1:0] plain_we;

  logic [DATA_W-1:0] plain_q [NUM_PLAIN];
  logic [DATA_W-1:0] plain_d [NUM_PLAIN];
  logic [DATA_W-1:0] flags_q, flags_d;
  logic [DIV_W-1:0]  div_q, div_d;

  assign widx  = bus_addr[ADDR_W-1:2];
  assign wr_en = bus_sel && bus_wr;
  assign rd_en = bus_sel && !bus_wr;

  assign wr_flags = wr_en && (int'(widx) == W_FLAGS);
  assign wr_count = wr_en && (int'(widx) == W_COUNT);
  assign wr_div   = wr_en && (int'(widx) == W_DIV);
  assign wr_evgen = wr_en && (int'(widx) == W_EVGEN);

  for (genvar g = 0; g < NUM_PLAIN; g++) begin : g_plain_dec
    assign plain_we[g] = wr_en && (int'(widx) == PLAIN_IDX[g]);
  end

  always_comb begin
    for (int i = 0; i < NUM_PLAIN; i++)
      plain_d[i] = plain_we[i] ? bus_wdata : plain_q[i];
    flags_d = flags_q;
    if (wr_flags)   flags_d = flags_q & bus_wdata;
    if (flag_set_i) flags_d[0] = 1'b1;
    div_d = wr_div ? bus_wdata[DIV_W-1:0] : div_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_PLAIN; i++) plain_q[i] <= '0;
      flags_q <= '0;
      div_q   <= '0;
    end else begin
      for (int i = 0; i < NUM_PLAIN; i++) plain_q[i] <= plain_d[i];
      flags_q <= flags_d;
      div_q   <= div_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (rd_en) begin
      for (int i = 0; i < NUM_PLAIN; i++)
        if (int'(widx) == PLAIN_IDX[i]) bus_rdata = plain_q[i];
      if (int'(widx) == W_FLAGS) bus_rdata = flags_q;
      if (int'(widx) == W_COUNT) bus_rdata = cnt_i;
      if (int'(widx) == W_DIV)   bus_rdata = DATA_W'(div_q);
    end
  end

  assign run_o          = plain_q[SLOT_CTRL][0];
  assign uie_o          = plain_q[SLOT_IRQEN][0];
  assign reload_o       = plain_q[SLOT_RELOAD];
  assign div_o          = div_q;
  assign cnt_load_o     = wr_count || (wr_evgen && bus_wdata[0]);
  assign cnt_load_val_o = wr_count ? bus_wdata : '0;
  assign div_restart_o  = cnt_load_o || wr_div;

  p_flag_and_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_flags && !flag_set_i) |=> (flags_q == ($past(flags_q) & $past(bus_wdata))));

  p_div_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_div |=> (div_q == $past(bus_wdata[DIV_W-1:0])));

  p_idle_rdata_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_sel |-> (bus_rdata == '0));

endmodule

// File: rtl/reload_timer.sv
module reload_timer #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 10,
  parameter int DIV_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o
);

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic              run, uie, tick, cnt_load, div_restart, evt;
  logic [DIV_W-1:0]  div_val;
  logic [DATA_W-1:0] reload_val, cnt_val, cnt_load_val;

  // Assert asynchronously, release on the clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  rtim_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .DIV_W(DIV_W)) u_regs (
    .clk(clk), .rst_n(rst_int_n),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cnt_i(cnt_val), .flag_set_i(evt),
    .run_o(run), .uie_o(uie), .div_o(div_val), .reload_o(reload_val),
    .cnt_load_o(cnt_load), .cnt_load_val_o(cnt_load_val),
    .div_restart_o(div_restart)
  );

  rtim_prescaler #(.DIV_W(DIV_W)) u_presc (
    .clk(clk), .rst_n(rst_int_n), .run_i(run),
    .restart_i(div_restart), .div_i(div_val), .tick_o(tick)
  );

  rtim_counter #(.CNT_W(DATA_W)) u_cnt (
    .clk(clk), .rst_n(rst_int_n), .tick_i(tick),
    .load_i(cnt_load), .load_val_i(cnt_load_val),
    .reload_i(reload_val), .uie_i(uie),
    .cnt_o(cnt_val), .evt_o(evt), .irq_o(irq_o)
  );

endmodule

// File: tb/tb_reload_timer.sv
module tb_reload_timer;

  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] OW = 2'd0;
  localparam logic [1:0] OR = 2'd1;
  localparam int NVEC = 51;

  // {op, addr, wdata, expected read data, expected irq}
  localparam logic [76:0] VEC [NVEC] = '{
    {OR, 10'h000, 32'h0,        32'h0,        1'b0},
    {OR, 10'h02C, 32'h0,        32'h0,        1'b0},
    {OW, 10'h028, 32'h00030002, 32'h0,        1'b0},
    {OR, 10'h028, 32'h0,        32'h2,        1'b0},
    {OW, 10'h02C, 32'h5,        32'h0,        1'b0},
    {OW, 10'h00C, 32'h1,        32'h0,        1'b0},
    {OW, 10'h000, 32'h1,        32'h0,        1'b0},
    {OR, 10'h024, 32'h0,        32'h0,        1'b0},
    {OR, 10'h024, 32'h0,        32'h0,        1'b0},
    {OR, 10'h024, 32'h0,        32'h0,        1'b0},
    {OR, 10'h024, 32'h0,        32'h1,        1'b0},
    {OR, 10'h024, 32'h0,        32'h1,        1'b0},
    {OR, 10'h024, 32'h0,        32'h1,        1'b0},
    {OR, 10'h024, 32'h0,        32'h2,        1'b0},
    {OR, 10'h010, 32'h0,        32'h0,        1'b0},
    {OR, 10'h024, 32'h0,        32'h2,        1'b0},
    {OR, 10'h024, 32'h0,        32'h3,        1'b0},
    {OR, 10'h024, 32'h0,        32'h3,        1'b0},
    {OR, 10'h024, 32'h0,        32'h3,        1'b0},
    {OR, 10'h024, 32'h0,        32'h4,        1'b0},
    {OR, 10'h024, 32'h0,        32'h4,        1'b0},
    {OR, 10'h024, 32'h0,        32'h4,        1'b0},
    {OR, 10'h024, 32'h0,        32'h5,        1'b1},
    {OR, 10'h010, 32'h0,        32'h1,        1'b0},
    {OR, 10'h024, 32'h0,        32'h5,        1'b0},
    {OR, 10'h024, 32'h0,        32'h0,        1'b0},
    {OW, 10'h010, 32'hFFFFFFFE, 32'h0,        1'b0},
    {OR, 10'h010, 32'h0,        32'h0,        1'b0},
    {OW, 10'h024, 32'h100,      32'h0,        1'b0},
    {OR, 10'h024, 32'h0,        32'h100,      1'b0},
    {OW, 10'h014, 32'h1,        32'h0,        1'b0},
    {OR, 10'h024, 32'h0,        32'h0,        1'b0},
    {OR, 10'h014, 32'h0,        32'h1,        1'b0},
    {OR, 10'h030, 32'h0,        32'h0,        1'b0},
    {OW, 10'h044, 32'hDEAD,     32'h0,        1'b0},
    {OR, 10'h044, 32'h0,        32'h0,        1'b0},
    {OW, 10'h03C, 32'hA5A50003, 32'h0,        1'b0},
    {OR, 10'h03C, 32'h0,        32'hA5A50003, 1'b0},
    {OR, 10'h034, 32'h0,        32'h0,        1'b0},
    {OW, 10'h050, 32'h5A,       32'h0,        1'b0},
    {OR, 10'h050, 32'h0,        32'h5A,       1'b0},
    {OW, 10'h02C, 32'h0,        32'h0,        1'b0},
    {OR, 10'h024, 32'h0,        32'h3,        1'b0},
    {OR, 10'h024, 32'h0,        32'h4,        1'b0},
    {OR, 10'h024, 32'h0,        32'h4,        1'b0},
    {OR, 10'h024, 32'h0,        32'h4,        1'b0},
    {OR, 10'h024, 32'h0,        32'h5,        1'b0},
    {OR, 10'h024, 32'h0,        32'h5,        1'b0},
    {OR, 10'h024, 32'h0,        32'h5,        1'b0},
    {OR, 10'h024, 32'h0,        32'h6,        1'b0},
    {OR, 10'h010, 32'h0,        32'h0,        1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [9:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  reload_timer dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic string vec_tag(int i);
    if (i < 2)  return "R1";
    if (i < 4)  return "R9";
    if (i < 22) return "R2";
    if (i < 24) return "R4";
    if (i < 26) return "R3";
    if (i < 28) return "R5";
    if (i < 30) return "R8";
    if (i < 33) return "R7";
    if (i < 41) return "R10";
    return "R6";
  endfunction

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic bus_write(logic [9:0] a, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
  endtask

  task automatic bus_read(logic [9:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a; bus_wdata = '0;
    #1 d = bus_rdata;
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] rd, rd2;
    bit seen;
    #(CLK_PERIOD * 3 + 2);
    check("R1", {31'b0, irq_o}, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    idle(4);

    // Vector walk: one bus operation per cycle.
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      bus_sel   = 1'b1;
      bus_wr    = (VEC[i][76:75] == OW);
      bus_addr  = VEC[i][74:65];
      bus_wdata = VEC[i][64:33];
      #1;
      check(vec_tag(i), {31'b0, irq_o}, {31'b0, VEC[i][0]});
      if (VEC[i][76:75] == OR) check(vec_tag(i), bus_rdata, VEC[i][32:1]);
    end
    idle(1);
    #1 check("R11", bus_rdata, 32'h0);

    // R4 gating by interrupt enable, R5 write-one keeps, R2 hold when stopped
    bus_write(10'h000, 0);
    bus_write(10'h00C, 0);
    bus_write(10'h028, 0);
    bus_write(10'h014, 1);
    bus_write(10'h010, 0);
    bus_write(10'h02C, 2);
    bus_write(10'h000, 1);
    seen = 1'b0;
    for (int k = 0; k < 8; k++) begin
      idle(1); #1 if (irq_o) seen = 1'b1;
    end
    check("R4", {31'b0, seen}, 32'h0);
    bus_read(10'h010, rd); check("R4", rd, 32'h0);
    bus_write(10'h00C, 1);
    seen = 1'b0;
    for (int k = 0; k < 6; k++) begin
      idle(1); #1 if (irq_o) seen = 1'b1;
    end
    check("R4", {31'b0, seen}, 32'h1);
    bus_write(10'h000, 0);
    bus_read(10'h010, rd); check("R4", rd, 32'h1);
    bus_write(10'h010, 1);
    bus_read(10'h010, rd); check("R5", rd, 32'h1);
    bus_write(10'h010, 0);
    bus_read(10'h010, rd); check("R5", rd, 32'h0);
    bus_read(10'h024, rd);
    idle(4);
    bus_read(10'h024, rd2); check("R2", rd2, rd);

    // R9 divider change keeps the count and slows from that edge
    bus_write(10'h02C, 0);
    bus_write(10'h024, 7);
    bus_write(10'h000, 1);
    bus_write(10'h028, 9);
    bus_read(10'h024, rd); check("R9", rd, 32'h8);
    idle(8);
    bus_read(10'h024, rd); check("R9", rd, 32'h8);
    bus_read(10'h024, rd); check("R9", rd, 32'h9);

    // R1 reset in the middle of a run
    idle(3);
    @(negedge clk); rst_n = 1'b0;
    #1 check("R1", {31'b0, irq_o}, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    idle(3);
    bus_read(10'h024, rd); check("R1", rd, 32'h0);
    bus_read(10'h000, rd); check("R1", rd, 32'h0);
    bus_read(10'h028, rd); check("R1", rd, 32'h0);
    bus_read(10'h03C, rd); check("R1", rd, 32'h0);
    bus_read(10'h050, rd); check("R1", rd, 32'h0);
    idle(1);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule